// File: doc/BRIEF.md
# Four-Level Priority Flow Scheduler

This block decides which flow is served next by a packet transmitter. It keeps one queue of flow identifiers for each of four priority levels. The two low bits of a flow identifier give its level. The upper bits name the flow inside that level. On each cycle the block offers the oldest identifier in the highest non-empty queue. The consumer takes it with a valid/ready handshake.

Flows enter a queue in two ways. Per-flow accounting upstream pushes a flow when it gets its first backlogged packet. Dequeue logic re-enters a flow that still holds packets after a service, at the tail of its own level. Because of this, backlogged flows inside one level take turns. A transmit-enable input stops all selection while it is low. When a re-entry and a push aim at the same level in the same cycle, the block stores the re-entry first. It parks the push for one cycle and writes it the next cycle. A write that cannot be stored raises a one-cycle overflow flag.

Top module: `flow_sched`

## Requirements
- R1: After reset all four queues are empty, `sel_valid` is 0 and `overflow` is 0.
- R2: The level of an identifier is its bits [1:0]: 3 is most urgent, 2 next, then 1, and 0 is served last. `sel_flow` always comes from the most urgent non-empty level.
- R3: Inside one level, identifiers leave in the order in which they were written.
- R4: A re-entered identifier is written at the tail of the queue for its own level, so it is served after every identifier already waiting there.
- R5: `sel_valid` is 1 exactly when `tx_en` is 1 and at least one queue holds an entry. While `tx_en` is 0 no entry is removed.
- R6: An entry is removed only in a cycle where both `sel_valid` and `sel_ready` are 1. Without a handshake, the queue contents stay the same.
- R7: A re-entry and a push to the same level in the same cycle store the re-entry first. The push follows one cycle later. If the parked push cannot leave because a later re-entry takes its level, a further push to that same level is dropped.
- R8: A write to a queue that already holds DEPTH entries, with no pop from that queue in the same cycle, is dropped. A push that can be neither written nor parked is also dropped. Each drop makes `overflow` 1 for exactly the following cycle.
- R9: An identifier written at a clock edge can be selected in the cycle that follows that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_en | input | 1 | Allows selection when high |
| push_valid | input | 1 | A newly backlogged flow is presented |
| push_flow | input | 16 | Identifier of the newly backlogged flow |
| reentry_valid | input | 1 | A served flow that is still backlogged is presented |
| reentry_flow | input | 16 | Identifier to re-enter |
| sel_ready | input | 1 | The consumer accepts the offered flow |
| sel_valid | output | 1 | A flow is offered |
| sel_flow | output | 16 | The offered flow identifier |
| overflow | output | 1 | One-cycle pulse after a write was dropped |

## Verification
The checker tests on every cycle that the offered flow belongs to a non-empty level with no non-empty level above it. It also tests that the total occupancy never falls without a handshake or while `tx_en` is low, that no queue count exceeds DEPTH, and that reset leaves everything empty. Some properties depend on history, and only the bench's scenarios can show them: first-in-first-out order inside a level, round-robin through re-entry, the one-cycle deferral of a colliding push, and which write is dropped when a queue is full. For these the bench compares each offered identifier against a queue model.

// File: rtl/flow_sched_pkg.sv
package flow_sched_pkg;
  localparam int NUM_LEVELS = 4;
  localparam int LEVEL_W    = $clog2(NUM_LEVELS);

  function automatic logic [LEVEL_W-1:0] level_of(input logic [LEVEL_W-1:0] low_bits);
    return low_bits;
  endfunction
endpackage

// File: rtl/flow_fifo.sv
module flow_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 512,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  output logic [W-1:0]  head,
  output logic          not_empty,
  output logic [CW-1:0] count,
  output logic          drop
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr, rd_next;
  logic [W-1:0]  head_mem, byp_data;
  logic          byp_q;
  logic          full, wr_ok, rd_ok;

  function automatic logic [AW-1:0] inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full      = (count == CW'(DEPTH));
  assign not_empty = (count != '0);
  assign rd_ok     = rd_en && not_empty;
  assign wr_ok     = wr_en && (!full || rd_ok);
  assign drop      = wr_en && !wr_ok;
  assign rd_next   = rd_ok ? inc(rd_ptr) : rd_ptr;

  // storage with registered read of the next head: block RAM friendly
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr] <= wr_data;
    head_mem <= mem[rd_next];
  end

  // a write landing on the slot about to become head is forwarded
  always_ff @(posedge clk) begin
    if (rst) begin
      byp_q    <= 1'b0;
      byp_data <= '0;
    end else begin
      byp_q    <= wr_ok && (wr_ptr == rd_next);
      byp_data <= wr_data;
    end
  end

  assign head = byp_q ? byp_data : head_mem;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_ok) wr_ptr <= inc(wr_ptr);
      rd_ptr <= rd_next;
      case ({wr_ok, rd_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/flow_prio_pick.sv
module flow_prio_pick #(
  parameter int N  = 4,
  localparam int LW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  ne,
  output logic          any,
  output logic [LW-1:0] lvl
);
  always_comb begin
    lvl = '0;
    for (int i = 0; i < N; i++) begin
      if (ne[i]) lvl = LW'(i);
    end
  end
  assign any = |ne;
endmodule

// File: rtl/flow_wr_arb.sv
module flow_wr_arb #(
  parameter int W = 16,
  parameter int N = 4,
  localparam int LW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                re_v,
  input  logic [W-1:0]        re_id,
  input  logic                pu_v,
  input  logic [W-1:0]        pu_id,
  output logic [N-1:0]        wr_en,
  output logic [N-1:0][W-1:0] wr_data,
  output logic                park_drop
);
  logic          hold_v;
  logic [W-1:0]  hold_id;
  logic [N-1:0]  taken;
  logic          hold_go, pu_park;
  logic [LW-1:0] re_l, hold_l, pu_l;

  assign re_l   = re_id[LW-1:0];
  assign hold_l = hold_id[LW-1:0];
  assign pu_l   = pu_id[LW-1:0];

  always_comb begin
    taken     = '0;
    wr_en     = '0;
    wr_data   = '0;
    hold_go   = 1'b0;
    pu_park   = 1'b0;
    park_drop = 1'b0;
    if (re_v) begin
      taken[re_l]   = 1'b1;
      wr_en[re_l]   = 1'b1;
      wr_data[re_l] = re_id;
    end
    if (hold_v && !taken[hold_l]) begin
      taken[hold_l]   = 1'b1;
      wr_en[hold_l]   = 1'b1;
      wr_data[hold_l] = hold_id;
      hold_go         = 1'b1;
    end
    if (pu_v) begin
      if (!taken[pu_l]) begin
        wr_en[pu_l]   = 1'b1;
        wr_data[pu_l] = pu_id;
      end else if (!hold_v || hold_go) begin
        pu_park = 1'b1;
      end else begin
        park_drop = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_v  <= 1'b0;
      hold_id <= '0;
    end else if (pu_park) begin
      hold_v  <= 1'b1;
      hold_id <= pu_id;
    end else if (hold_go) begin
      hold_v  <= 1'b0;
    end
  end
endmodule

// File: rtl/flow_sched.sv
module flow_sched
  import flow_sched_pkg::*;
#(
  parameter int ID_W  = 16,
  parameter int DEPTH = 512,
  localparam int NLVL  = NUM_LEVELS,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tx_en,
  input  logic            push_valid,
  input  logic [ID_W-1:0] push_flow,
  input  logic            reentry_valid,
  input  logic [ID_W-1:0] reentry_flow,
  input  logic            sel_ready,
  output logic            sel_valid,
  output logic [ID_W-1:0] sel_flow,
  output logic            overflow
);
  logic [NLVL-1:0]             wr_en, lvl_ne, pop, fifo_drop;
  logic [NLVL-1:0][ID_W-1:0]   wr_data, heads;
  logic [NLVL-1:0][CNT_W-1:0]  lvl_cnt;
  logic                        park_drop, any_ne;
  logic [LEVEL_W-1:0]          top_lvl;

  flow_wr_arb #(.W(ID_W), .N(NLVL)) u_arb (
    .clk(clk), .rst(rst),
    .re_v(reentry_valid), .re_id(reentry_flow),
    .pu_v(push_valid), .pu_id(push_flow),
    .wr_en(wr_en), .wr_data(wr_data), .park_drop(park_drop)
  );

  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    assign pop[g] = sel_valid && sel_ready && (top_lvl == LEVEL_W'(g));
    flow_fifo #(.W(ID_W), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst(rst),
      .wr_en(wr_en[g]), .wr_data(wr_data[g]),
      .rd_en(pop[g]),
      .head(heads[g]), .not_empty(lvl_ne[g]),
      .count(lvl_cnt[g]), .drop(fifo_drop[g])
    );
  end

  flow_prio_pick #(.N(NLVL)) u_pick (
    .ne(lvl_ne), .any(any_ne), .lvl(top_lvl)
  );

  assign sel_valid = tx_en && any_ne;
  assign sel_flow  = heads[level_of(top_lvl)];

  always_ff @(posedge clk) begin
    if (rst) overflow <= 1'b0;
    else     overflow <= park_drop || (|fifo_drop);
  end
endmodule

// File: rtl/flow_sched_chk.sv
module flow_sched_chk #(
  parameter int N     = 4,
  parameter int W     = 16,
  parameter int CW    = 10,
  parameter int DEPTH = 512
) (
  input logic               clk,
  input logic               rst,
  input logic               tx_en,
  input logic               sel_valid,
  input logic               sel_ready,
  input logic [W-1:0]       sel_flow,
  input logic               overflow,
  input logic [N-1:0]       lvl_ne,
  input logic [N-1:0][CW-1:0] lvl_cnt
);
  logic [CW+3:0] total;
  logic [N-1:0]  higher_busy;
  logic          over_cap;

  always_comb begin
    total       = '0;
    higher_busy = '0;
    over_cap    = 1'b0;
    for (int i = 0; i < N; i++) begin
      total = total + (CW+4)'(lvl_cnt[i]);
      if (i > int'(sel_flow[1:0])) higher_busy[i] = lvl_ne[i];
      if (int'(lvl_cnt[i]) > DEPTH) over_cap = 1'b1;
    end
  end

  // R1
  reset_empty_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (total == '0 && !sel_valid && !overflow));

  // R2
  top_level_chk: assert property (@(posedge clk) disable iff (rst)
    sel_valid |-> (lvl_ne[sel_flow[1:0]] && higher_busy == '0));

  // R6
  no_pop_without_hs_chk: assert property (@(posedge clk) disable iff (rst)
    !(sel_valid && sel_ready) |=> total >= $past(total));

  // R5
  no_pop_tx_off_chk: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> total >= $past(total));

  // R8
  depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
    !over_cap);
endmodule

bind flow_sched flow_sched_chk #(.N(NLVL), .W(ID_W), .CW(CNT_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .tx_en(tx_en), .sel_valid(sel_valid),
  .sel_ready(sel_ready), .sel_flow(sel_flow), .overflow(overflow),
  .lvl_ne(lvl_ne), .lvl_cnt(lvl_cnt)
);

// File: tb/flow_sched_tb.sv
module flow_sched_tb;
  localparam int CLK_PERIOD = 10;
  localparam int D = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tx_en = 1'b0, push_valid = 1'b0, reentry_valid = 1'b0, sel_ready = 1'b0;
  logic [15:0] push_flow = '0, reentry_flow = '0;
  logic        sel_valid, overflow;
  logic [15:0] sel_flow;

  int errors = 0, checks = 0;
  string tag = "R1";
  bit done = 0;

  logic [15:0] mq [4][$];
  bit          m_hv = 0;
  logic [15:0] m_hid = '0;
  bit          m_ovf = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flow_sched #(.ID_W(16), .DEPTH(D)) u_dut (
    .clk(clk), .rst(rst), .tx_en(tx_en),
    .push_valid(push_valid), .push_flow(push_flow),
    .reentry_valid(reentry_valid), .reentry_flow(reentry_flow),
    .sel_ready(sel_ready), .sel_valid(sel_valid), .sel_flow(sel_flow),
    .overflow(overflow)
  );

  function automatic int top_level();
    for (int l = 3; l >= 0; l--) if (mq[l].size() > 0) return l;
    return -1;
  endfunction

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic void m_write(input logic [15:0] id);
    int l = int'(id[1:0]);
    if (mq[l].size() < D) mq[l].push_back(id);
    else m_ovf = 1;
  endfunction

  // inputs already driven after negedge; compare, then advance model and clock
  task automatic cyc();
    int tl;
    bit [3:0] taken = '0;
    bit hgo = 0, park = 0;
    #1;
    tl = top_level();
    chk("sel_valid", 32'(sel_valid), 32'(tx_en && tl >= 0));
    if (tx_en && tl >= 0) chk("sel_flow", 32'(sel_flow), 32'(mq[tl][0]));
    chk("overflow", 32'(overflow), 32'(m_ovf));
    m_ovf = 0;
    if (tx_en && sel_ready && tl >= 0) void'(mq[tl].pop_front());
    if (reentry_valid) begin taken[reentry_flow[1:0]] = 1; m_write(reentry_flow); end
    if (m_hv && !taken[m_hid[1:0]]) begin taken[m_hid[1:0]] = 1; m_write(m_hid); hgo = 1; end
    if (push_valid) begin
      if (!taken[push_flow[1:0]]) m_write(push_flow);
      else if (!m_hv || hgo) park = 1;
      else m_ovf = 1;
    end
    if (park) begin m_hv = 1; m_hid = push_flow; end
    else if (hgo) m_hv = 0;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_in();
    push_valid = 0; reentry_valid = 0;
  endtask

  task automatic drain(input int n);
    idle_in(); tx_en = 1; sel_ready = 1;
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic push1(input logic [15:0] id);
    idle_in(); push_valid = 1; push_flow = id; cyc(); idle_in();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1: empty after reset even with selection enabled
    tag = "R1"; tx_en = 1; sel_ready = 1;
    cyc(); cyc();

    // R2: one flow per level, served from most urgent down
    tag = "R2"; tx_en = 0;
    push1(16'h0010); push1(16'h0021); push1(16'h0032); push1(16'h0043);
    drain(6);

    // R9: written entry offered in the very next cycle
    tag = "R9"; tx_en = 1; sel_ready = 0;
    push1(16'h0101); cyc();
    drain(3);

    // R3: order inside one level
    tag = "R3"; tx_en = 0;
    push1(16'h1002); push1(16'h2002); push1(16'h3002);
    drain(5);

    // R4: re-entry goes behind waiting flows
    tag = "R4"; tx_en = 0;
    push1(16'hA001); push1(16'hB001);
    tx_en = 1; sel_ready = 1; reentry_valid = 1; reentry_flow = 16'hA001; cyc();
    idle_in(); drain(4);

    // R5: transmit disabled holds everything
    tag = "R5"; tx_en = 0; sel_ready = 1;
    push1(16'h0053); cyc(); cyc();
    drain(3);

    // R6: no handshake, no removal
    tag = "R6"; tx_en = 1; sel_ready = 0;
    push1(16'h0060); cyc(); cyc();
    drain(3);

    // R7: push and re-entry collide on level 2
    tag = "R7"; tx_en = 0;
    push_valid = 1; push_flow = 16'h0702; reentry_valid = 1; reentry_flow = 16'h0802; cyc();
    // parked push blocked again by re-entry; second push to same level dropped
    push_valid = 1; push_flow = 16'h0902; reentry_valid = 1; reentry_flow = 16'h0A02; cyc();
    idle_in(); cyc(); cyc();
    drain(8);

    // R8: overfill level 1 with nothing leaving
    tag = "R8"; tx_en = 0;
    for (int i = 0; i < D + 2; i++) push1(16'((i << 2) | 1));
    cyc();
    drain(D + 4);

    // random mix, exercising R2 and R3 with R4 re-entries
    tag = "R3";
    for (int i = 0; i < 4000; i++) begin
      tx_en = ($urandom % 8) != 0;
      sel_ready = ($urandom % 4) != 0;
      push_valid = ($urandom % 3) == 0;
      push_flow = 16'($urandom);
      reentry_valid = ($urandom % 3) == 0;
      reentry_flow = 16'($urandom);
      cyc();
    end
    drain(4 * D + 4);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule